// File: doc/BRIEF.md
# Serial Configuration Stream Synchronizer and Packet Parser

This block sits at the front of a serial configuration port. It receives the configuration stream one bit per clock, qualified by a valid flag, and hunts for a fixed 32-bit synchronization pattern in a sliding window, so the pattern is found at any bit alignment. Until the pattern has been seen, every bit is discarded: no packet is decoded and the serial output idles high.

Once synchronized, the block groups the following valid bits into 32-bit words, most significant bit first. It decodes packet headers and follows each write packet's word count. Payload bits bound for the loop-out register are echoed on a serial output pin after a fixed pipeline delay. Payload words bound for the command register are presented on a one-cycle strobe with the word. Payloads for any other register are consumed and dropped. Synchronization holds until reset.

The input has no back-pressure: every cycle with the valid flag high delivers one bit, and the block always accepts it. Cycles with the valid flag low are skipped and count toward nothing except the fixed output delay, which is measured in clock cycles.

Top module: `cfg_sync_parser`

## Requirements
- R1: The pattern 0xAA995566 is detected over the last 32 valid bits at any alignment; `synced` goes high in the cycle right after the cycle that presents the pattern's final bit.
- R2: Before synchronization nothing is decoded: command and loop-out headers and 0xFFFFFFFF dummy words cause no `cmd_strobe`, and `dout` stays 1.
- R3: Once high, `synced` stays high until reset.
- R4: After synchronization, words are built from 32 valid bits, the first bit received becoming bit 31; cycles with `bit_valid` low are skipped.
- R5: A header is a write when bits [31:29] = 001 and bits [28:27] = 10; bits [17:13] give the register address and bits [10:0] the payload word count. Any other header is a single word that has no effect.
- R6: For a write to address 4 (command), each payload word produces `cmd_strobe` high for exactly one cycle, with `cmd_word` equal to the word, in the cycle after the one that presents the word's last bit.
- R7: For a write to address 8 (loop-out), each payload bit presented in cycle c drives `dout` in cycle c+40; in every cycle that carries no such bit, `dout` is 1.
- R8: Loop-out writes may appear any number of times anywhere after synchronization and may carry several words; every payload bit is emitted.
- R9: The payload of a write to any other address is consumed and discarded; the word after it is decoded as a header.
- R10: A write header whose word count is 0 has no payload; the next word is a header.
- R11: During reset and right after it, `synced` = 0, `dout` = 1 and `cmd_strobe` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial configuration data |
| bit_valid | input | 1 | `bit_in` carries a bit this cycle |
| synced | output | 1 | Synchronization pattern has been seen |
| dout | output | 1 | Delayed loop-out data; idles high |
| cmd_strobe | output | 1 | One-cycle pulse per command payload word |
| cmd_word | output | 32 | Command payload word, valid with `cmd_strobe` |

## Verification
The hardest case to reach from the ports is a payload that looks like a valid header. This must be dropped without breaking word framing. The stimulus sends an unknown-address write whose payloads are a command header and a loop-out header. It also sends a zero-count command header followed by a real one, so a wrong count or a mis-framed word shows up as an extra or missing strobe. Synchronization is reached at an odd bit offset, behind dummy words and a command header, and idle cycles are placed inside payload words. This exercises both the sliding window and the fixed cycle-based output delay.

// File: rtl/cfg_sp_pkg.sv
package cfg_sp_pkg;
  localparam int WORD_W = 32;

  localparam logic [2:0] HDR_TYPE1 = 3'b001;
  localparam logic [1:0] HDR_OP_WR = 2'b10;
  localparam logic [4:0] ADDR_LOOP = 5'd8;
  localparam logic [4:0] ADDR_CMD  = 5'd4;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LOOP = 2'd1,
    TGT_CMD  = 2'd2
  } tgt_e;

  typedef struct packed {
    logic v;
    logic d;
  } lbit_t;
endpackage

// File: rtl/cfg_sync_hunt.sv
module cfg_sync_hunt #(
  parameter int W = 32,
  parameter logic [W-1:0] PATTERN = 32'hAA995566
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic synced
);
  logic [W-2:0] window;
  logic [W-1:0] probe;

  assign probe = {window, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window <= '0;
      synced <= 1'b0;
    end else if (bit_valid && !synced) begin
      window <= probe[W-2:0];
      if (probe == PATTERN) synced <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_word_gather.sv
module cfg_word_gather #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_in,
  output logic         word_done,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-2:0]  acc;
  logic [CW-1:0] nbits;

  assign word      = {acc, bit_in};
  assign word_done = en && (nbits == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      nbits <= '0;
    end else if (en) begin
      acc   <= word[W-2:0];
      nbits <= word_done ? '0 : nbits + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_pkt_decode.sv
module cfg_pkt_decode
  import cfg_sp_pkg::*;
#(
  parameter int W    = 32,
  parameter int CNT_W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         word_done,
  input  logic [W-1:0] word,
  output logic         loop_bit,
  output logic         cmd_strobe,
  output logic [W-1:0] cmd_word
);
  logic             in_pay;
  tgt_e             tgt;
  logic [CNT_W-1:0] remain;

  logic             is_wr;
  logic [4:0]       h_addr;
  logic [CNT_W-1:0] h_cnt;
  tgt_e             h_tgt;

  assign is_wr  = (word[31:29] == HDR_TYPE1) && (word[28:27] == HDR_OP_WR);
  assign h_addr = word[17:13];
  assign h_cnt  = word[CNT_W-1:0];

  always_comb begin
    if (h_addr == ADDR_LOOP)     h_tgt = TGT_LOOP;
    else if (h_addr == ADDR_CMD) h_tgt = TGT_CMD;
    else                         h_tgt = TGT_NONE;
  end

  assign loop_bit = en && in_pay && (tgt == TGT_LOOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pay     <= 1'b0;
      tgt        <= TGT_NONE;
      remain     <= '0;
      cmd_strobe <= 1'b0;
      cmd_word   <= '0;
    end else begin
      cmd_strobe <= 1'b0;
      if (word_done) begin
        if (!in_pay) begin
          if (is_wr && (h_cnt != '0)) begin
            in_pay <= 1'b1;
            remain <= h_cnt;
            tgt    <= h_tgt;
          end
        end else begin
          if (tgt == TGT_CMD) begin
            cmd_strobe <= 1'b1;
            cmd_word   <= word;
          end
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) in_pay <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_loop_delay.sv
module cfg_loop_delay
  import cfg_sp_pkg::*;
#(
  parameter int LAT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_v,
  input  logic in_d,
  output logic dout
);
  lbit_t stg [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    lbit_t src;
    if (g == 0) begin : g_head
      assign src = '{v: in_v, d: in_d};
    end else begin : g_body
      assign src = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '{v: 1'b0, d: 1'b1};
      else        stg[g] <= src;
    end
  end

  assign dout = stg[LAT-1].v ? stg[LAT-1].d : 1'b1;
endmodule

// File: rtl/cfg_sync_parser.sv
module cfg_sync_parser
  import cfg_sp_pkg::*;
#(
  parameter logic [31:0] SYNC_WORD = 32'hAA995566,
  parameter int          LOOP_LAT  = 40,
  parameter int          CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_valid,
  output logic              synced,
  output logic              dout,
  output logic              cmd_strobe,
  output logic [WORD_W-1:0] cmd_word
);
  logic              take;
  logic              word_done;
  logic [WORD_W-1:0] word;
  logic              loop_bit;

  assign take = synced && bit_valid;

  cfg_sync_hunt #(.W(WORD_W), .PATTERN(SYNC_WORD)) u_hunt (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .synced(synced)
  );

  cfg_word_gather #(.W(WORD_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .en(take), .bit_in(bit_in),
    .word_done(word_done), .word(word)
  );

  cfg_pkt_decode #(.W(WORD_W), .CNT_W(CNT_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .en(take), .word_done(word_done), .word(word),
    .loop_bit(loop_bit), .cmd_strobe(cmd_strobe), .cmd_word(cmd_word)
  );

  cfg_loop_delay #(.LAT(LOOP_LAT)) u_delay (
    .clk(clk), .rst_n(rst_n), .in_v(loop_bit), .in_d(bit_in), .dout(dout)
  );
endmodule

// File: rtl/cfg_sync_parser_chk.sv
module cfg_sync_parser_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic synced,
  input logic dout,
  input logic cmd_strobe
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> dout);

  p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);

  p_sync_on_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(bit_valid));

  p_cmd_after_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> synced);

  p_cmd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);
endmodule

bind cfg_sync_parser cfg_sync_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .synced(synced),
  .dout(dout), .cmd_strobe(cmd_strobe)
);

// File: tb/cfg_sync_parser_test.sv
module cfg_sync_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 40;
  localparam logic [31:0] SYNC = 32'hAA995566;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b1;
  logic        bit_valid = 1'b0;
  logic        synced, dout, cmd_strobe;
  logic [31:0] cmd_word;

  int n_tests = 0;
  int n_fail  = 0;
  int ecount  = 0;
  bit done    = 0;

  cfg_sync_parser uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .synced(synced), .dout(dout), .cmd_strobe(cmd_strobe), .cmd_word(cmd_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit          m_synced;
  logic [31:0] m_win;
  logic [31:0] m_word;
  int          m_nb;
  bit          m_pay;
  int          m_rem;
  int          m_tgt;
  bit          m_stb;
  logic [31:0] m_cw;
  bit          sched [int];

  task automatic model_word(input logic [31:0] w);
    if (!m_pay) begin
      if (w[31:29] == 3'd1 && w[28:27] == 2'd2 && w[10:0] != 0) begin
        m_pay = 1; m_rem = int'(w[10:0]); m_tgt = int'(w[17:13]);
      end
    end else begin
      if (m_tgt == 4) begin m_stb = 1; m_cw = w; end
      m_rem--;
      if (m_rem == 0) m_pay = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_synced = 0; m_win = '0; m_word = '0; m_nb = 0; m_pay = 0;
      m_rem = 0; m_tgt = 0; m_stb = 0; m_cw = '0; sched.delete();
    end else begin
      m_stb = 0;
      if (bit_valid) begin
        if (!m_synced) begin
          m_win = {m_win[30:0], bit_in};
          if (m_win == SYNC) m_synced = 1;
        end else begin
          if (m_pay && m_tgt == 8) sched[ecount + LAT] = bit_in;
          m_word = {m_word[30:0], bit_in};
          m_nb++;
          if (m_nb == 32) begin m_nb = 0; model_word(m_word); end
        end
      end
    end
    ecount++;
  end

  // observation counters
  int          n_stb, n_zero, rise_e;
  logic [31:0] last_cw;
  bit          prev_sync;

  task automatic clear_obs();
    n_stb = 0; n_zero = 0; rise_e = -1; last_cw = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_dout;
      e_dout = sched.exists(ecount) ? sched[ecount] : 1'b1;
      if (sched.exists(ecount)) sched.delete(ecount);
      chk("R1/R3 synced per cycle", {31'd0, synced}, {31'd0, m_synced});
      chk("R7 dout per cycle", {31'd0, dout}, {31'd0, e_dout});
      chk("R6 cmd_strobe per cycle", {31'd0, cmd_strobe}, {31'd0, m_stb});
      if (m_stb) chk("R6 cmd_word per cycle", cmd_word, m_cw);
      if (cmd_strobe) begin n_stb++; last_cw = cmd_word; end
      if (!dout) n_zero++;
      if (synced && !prev_sync) rise_e = ecount;
      prev_sync = synced;
    end else begin
      prev_sync = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (ecount > WATCHDOG && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", ecount, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic send_bit(input logic b, input logic v);
    @(posedge clk); #1;
    bit_in = b; bit_valid = v;
  endtask

  task automatic send_word(input logic [31:0] w, input bit gaps);
    for (int i = 31; i >= 0; i--) begin
      if (gaps && (i % 7 == 3)) send_bit(1'b0, 1'b0);
      send_bit(w[i], 1'b1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 synced in reset", {31'd0, synced}, 32'd0);
    chk("R11 dout in reset", {31'd0, dout}, 32'd1);
    chk("R11 cmd_strobe in reset", {31'd0, cmd_strobe}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 synced after reset", {31'd0, synced}, 32'd0);
    chk("R11 dout after reset", {31'd0, dout}, 32'd1);
    clear_obs();
  endtask

  int sync_e;
  int stb_presync;

  initial begin
    clear_obs();
    do_reset();

    // Scenario 1: junk before sync, odd alignment, gaps inside payloads
    send_word(32'h30008001, 0);
    send_word(32'h00000000, 0);
    send_word(32'h30010001, 0);
    send_word(32'h00000000, 0);
    send_word(32'hFFFFFFFF, 0);
    send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
    send_word(SYNC, 0);
    sync_e = ecount;
    idle(3);
    chk("R1 synced rises one cycle after last pattern bit", rise_e, sync_e + 1);
    chk("R2 no command strobe before sync", n_stb, 0);
    chk("R2 dout stayed high before sync", n_zero, 0);
    stb_presync = n_stb;
    send_word(32'h30010001, 0);
    send_word(32'h00000000, 1);
    send_word(32'h30008001, 0);
    send_word(32'hDEADBEEF, 1);
    idle(60);
    chk("R6 one command strobe", n_stb, 1);
    chk("R4 command word assembled MSB first across gaps", last_cw, 32'hDEADBEEF);
    chk("R7 zero payload gives 32 low cycles", n_zero, 32);

    // Scenario 2: multi-word loop-out, unknown address, zero count, non-write headers
    do_reset();
    send_word(SYNC, 0);
    send_word(32'h30010002, 0);
    send_word(32'hA5A5A5A5, 0);
    send_word(32'h0F0F00FF, 0);
    send_word(32'h3000A002, 0);
    send_word(32'h30008001, 0);
    send_word(32'h30010001, 0);
    send_word(32'h30008000, 0);
    send_word(32'h30008001, 0);
    send_word(32'h00000042, 0);
    idle(5);
    chk("R9 unknown-address payload dropped", n_stb, 1);
    chk("R10 zero-count header then real command", last_cw, 32'h00000042);
    send_word(32'h48000005, 0);
    send_word(32'h28008001, 0);
    send_word(32'h30008001, 0);
    send_word(32'h11111111, 0);
    send_word(32'h30010001, 1);
    send_word(32'hFFFF0000, 0);
    idle(60);
    chk("R5 non-write headers ignored", n_stb, 2);
    chk("R5 command after ignored headers", last_cw, 32'h11111111);
    chk("R8 all loop-out writes emitted", n_zero, 48);
    chk("R3 synced still held", {31'd0, synced}, 32'd1);

    do_reset();
    chk("R11 synced cleared by reset", {31'd0, synced}, 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule